// File: doc/BRIEF.md
# Configuration Stream Header Inspector

This block sits on a 32-bit configuration stream that flows over a valid/ready handshake. It forwards every word unchanged. While the words pass, it numbers the accepted words from the start of the stream and picks two indicators out of two fixed header positions. The first indicator says whether the image is encrypted. The second says whether the image is compressed.

When the second header word has been accepted, the block works out the two settings that the configuration datapath needs. One is a 2-bit clock-to-data ratio code. The other is a one-bit configuration-width select. A one-cycle pulse marks these settings as valid.

A stream that ends before its header is complete cannot be classified, so the block raises a sticky error. A start-of-stream pulse clears all captured state and begins a new count.

Top module: `hdr_inspector`

## Requirements
- R1: The stream passes through combinationally and unchanged: `dn_valid` equals `up_valid`, `dn_data` equals `up_data`, and `up_ready` equals `dn_ready`.
- R2: A word counts only when `up_valid` and `dn_ready` are both high (a beat). Beats are numbered from 0 after `sos`, and a beat in the same cycle as `sos` is word 0. The count stops at 230, and stalled cycles do not advance it.
- R3: `is_encrypted` is 1 when bits [3:2] of word 69 are nonzero, and 0 otherwise.
- R4: `is_compressed` is 1 when bit 1 of word 229 is 0, and 0 when that bit is 1.
- R5: `res_valid` is high for exactly one cycle, in the cycle after word 229 is accepted, and at most once per stream.
- R6: `ratio_code` encodes 0 = x1, 1 = x2, 2 = x4 and 3 = x8. An image that is neither compressed nor encrypted gets code 0.
- R7: The base code is 2 (x4) when the image is compressed, or else 1 (x2) when it is only encrypted. When `cfg_w32` (sampled with word 229) is 1, a nonzero base code is raised by one. `width_sel` reports that sampled `cfg_w32`.
- R8: A beat with `up_last` high at a word index below 229 sets the sticky `short_err` from the next cycle on. No `res_valid` follows for that stream.
- R9: After reset or after `sos`, the outputs `ratio_code`, `width_sel`, `is_encrypted`, `is_compressed`, `short_err` and `res_valid` are all 0.
- R10: Once computed, `ratio_code` and `width_sel` hold until the next `sos`. Words beyond index 229 do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sos | input | 1 | Start-of-stream pulse; clears state |
| cfg_w32 | input | 1 | 1 selects 32-bit configuration width, 0 selects 16-bit |
| up_valid | input | 1 | Upstream word valid |
| up_ready | output | 1 | Upstream ready |
| up_data | input | 32 | Upstream word |
| up_last | input | 1 | Marks the final word of the stream |
| dn_valid | output | 1 | Downstream word valid |
| dn_ready | input | 1 | Downstream ready |
| dn_data | output | 32 | Downstream word |
| res_valid | output | 1 | One-cycle pulse: header result valid |
| ratio_code | output | 2 | Clock-to-data ratio code |
| width_sel | output | 1 | Configuration width select |
| is_encrypted | output | 1 | Encryption indicator |
| is_compressed | output | 1 | Compression indicator |
| short_err | output | 1 | Sticky error: stream ended before the header was complete |

## Verification
The checker watches every cycle for these properties:
- the word index never passes its ceiling;
- the result pulse lasts one cycle and follows an accepted word 229;
- the ratio code agrees with the reported flags and width;
- an error never coincides with a result;
- `sos` clears the outputs;
- the ratio holds between results.

Only the bench scenarios can show the following:
- that the flags come from the right word positions and bits under random back-pressure;
- that the per-stream result is correct for every combination of encryption field, compression bit and width;
- that streams of 229 words or fewer raise the error while streams of 230 words or more do not.

// File: rtl/hdr_inspector_pkg.sv
package hdr_inspector_pkg;

   typedef enum logic [1:0] {
      RATIO_X1 = 2'd0,
      RATIO_X2 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X8 = 2'd3
   } ratio_e;

   // Base step from image kind, then one step up for the wide interface.
   function automatic ratio_e pick_ratio(input logic comp, input logic encr,
                                         input logic wide);
      ratio_e base;
      if (comp)
         base = RATIO_X4;
      else if (encr)
         base = RATIO_X2;
      else
         base = RATIO_X1;
      if (wide && (base != RATIO_X1))
         base = ratio_e'(base + 2'd1);
      return base;
   endfunction

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
   parameter int LIMIT = 230,
   parameter int IDX_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             beat,
   output logic [IDX_W-1:0] idx_q
);
   localparam logic [IDX_W-1:0] CEIL = IDX_W'(LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (restart)
         idx_q <= beat ? IDX_W'(1) : '0;
      else if (beat && (idx_q != CEIL))
         idx_q <= idx_q + IDX_W'(1);
   end
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 8,
   parameter int ENC_IDX    = 69,
   parameter int ENC_LSB    = 2,
   parameter int ENC_W      = 2,
   parameter int CMP_IDX    = 229,
   parameter int CMP_BIT    = 1,
   parameter bit CMP_ACT_LO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              beat,
   input  logic [IDX_W-1:0]  cur_idx,
   input  logic [DATA_W-1:0] data,
   output logic              enc_q,
   output logic              cmp_q,
   output logic              cmp_hit,
   output logic              cmp_now,
   output logic              done_q
);
   localparam logic [IDX_W-1:0] ENC_I = IDX_W'(ENC_IDX);
   localparam logic [IDX_W-1:0] CMP_I = IDX_W'(CMP_IDX);

   logic enc_now;
   logic enc_hit;

   generate
      if (ENC_W == 1) begin : g_enc_bit
         assign enc_now = data[ENC_LSB];
      end else begin : g_enc_field
         assign enc_now = |data[ENC_LSB +: ENC_W];
      end
      if (CMP_ACT_LO) begin : g_cmp_lo
         assign cmp_now = ~data[CMP_BIT];
      end else begin : g_cmp_hi
         assign cmp_now = data[CMP_BIT];
      end
   endgenerate

   assign enc_hit = beat && (cur_idx == ENC_I);
   assign cmp_hit = beat && (cur_idx == CMP_I);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enc_q  <= 1'b0;
         cmp_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= cmp_hit;
         if (enc_hit)
            enc_q <= enc_now;
         else if (restart)
            enc_q <= 1'b0;
         if (cmp_hit)
            cmp_q <= cmp_now;
         else if (restart)
            cmp_q <= 1'b0;
      end
   end
endmodule

// File: rtl/hdr_len_guard.sv
module hdr_len_guard #(
   parameter int IDX_W   = 8,
   parameter int CMP_IDX = 229
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             beat,
   input  logic             last,
   input  logic [IDX_W-1:0] cur_idx,
   output logic             err_q
);
   localparam logic [IDX_W-1:0] CMP_I = IDX_W'(CMP_IDX);

   logic early_end;
   assign early_end = beat && last && (cur_idx < CMP_I);

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (early_end)
         err_q <= 1'b1;
      else if (restart)
         err_q <= 1'b0;
   end
endmodule

// File: rtl/hdr_ratio_reg.sv
module hdr_ratio_reg
   import hdr_inspector_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       load,
   input  logic       comp,
   input  logic       encr,
   input  logic       wide,
   output logic [1:0] ratio_q,
   output logic       wide_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= 2'd0;
         wide_q  <= 1'b0;
      end else if (load) begin
         ratio_q <= pick_ratio(comp, encr, wide);
         wide_q  <= wide;
      end else if (restart) begin
         ratio_q <= 2'd0;
         wide_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/hdr_inspector.sv
module hdr_inspector #(
   parameter int DATA_W  = 32,
   parameter int ENC_IDX = 69,
   parameter int ENC_LSB = 2,
   parameter int ENC_W   = 2,
   parameter int CMP_IDX = 229,
   parameter int CMP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sos,
   input  logic              cfg_w32,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   input  logic              up_last,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data,
   output logic              res_valid,
   output logic [1:0]        ratio_code,
   output logic              width_sel,
   output logic              is_encrypted,
   output logic              is_compressed,
   output logic              short_err
);
   localparam int HDR_LEN = CMP_IDX + 1;
   localparam int IDX_W   = $clog2(HDR_LEN + 1);

   generate
      if (CMP_IDX <= ENC_IDX) begin : g_bad_order
         $error("compression word must follow encryption word");
      end
      if (ENC_LSB + ENC_W > DATA_W) begin : g_bad_enc
         $error("encryption field exceeds data width");
      end
      if (CMP_BIT >= DATA_W) begin : g_bad_cmp
         $error("compression bit exceeds data width");
      end
   endgenerate

   logic             beat;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cur_idx;
   logic             cmp_hit;
   logic             cmp_now;
   logic             enc_q;
   logic             cmp_q;
   logic             done_q;

   assign dn_valid = up_valid;
   assign dn_data  = up_data;
   assign up_ready = dn_ready;
   assign beat     = up_valid && dn_ready;
   assign cur_idx  = sos ? '0 : idx_q;

   hdr_word_counter #(.LIMIT(HDR_LEN), .IDX_W(IDX_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .restart(sos), .beat(beat), .idx_q(idx_q)
   );

   hdr_flag_capture #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .ENC_IDX(ENC_IDX), .ENC_LSB(ENC_LSB),
      .ENC_W(ENC_W), .CMP_IDX(CMP_IDX), .CMP_BIT(CMP_BIT), .CMP_ACT_LO(1'b1)
   ) cap_i (
      .clk(clk), .rst_n(rst_n), .restart(sos), .beat(beat), .cur_idx(cur_idx),
      .data(up_data), .enc_q(enc_q), .cmp_q(cmp_q), .cmp_hit(cmp_hit),
      .cmp_now(cmp_now), .done_q(done_q)
   );

   hdr_len_guard #(.IDX_W(IDX_W), .CMP_IDX(CMP_IDX)) guard_i (
      .clk(clk), .rst_n(rst_n), .restart(sos), .beat(beat), .last(up_last),
      .cur_idx(cur_idx), .err_q(short_err)
   );

   hdr_ratio_reg ratio_i (
      .clk(clk), .rst_n(rst_n), .restart(sos), .load(cmp_hit),
      .comp(cmp_now), .encr(enc_q), .wide(cfg_w32),
      .ratio_q(ratio_code), .wide_q(width_sel)
   );

   assign res_valid     = done_q;
   assign is_encrypted  = enc_q;
   assign is_compressed = cmp_q;
endmodule

// File: rtl/hdr_inspector_chk.sv
module hdr_inspector_chk #(
   parameter int IDX_W   = 8,
   parameter int CMP_IDX = 229
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sos,
   input logic             up_valid,
   input logic             dn_ready,
   input logic [IDX_W-1:0] idx_q,
   input logic [IDX_W-1:0] cur_idx,
   input logic             res_valid,
   input logic [1:0]       ratio_code,
   input logic             width_sel,
   input logic             is_encrypted,
   input logic             is_compressed,
   input logic             short_err
);
   localparam logic [IDX_W-1:0] CEIL  = IDX_W'(CMP_IDX + 1);
   localparam logic [IDX_W-1:0] CMP_I = IDX_W'(CMP_IDX);

   // R2
   idx_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= CEIL);

   // R5
   res_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R5
   res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(up_valid && dn_ready && (cur_idx == CMP_I)));

   // R6
   plain_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !is_compressed && !is_encrypted) |-> (ratio_code == 2'd0));

   // R7
   comp_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && is_compressed) |-> (ratio_code == (width_sel ? 2'd3 : 2'd2)));

   // R7
   encr_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && is_encrypted && !is_compressed)
         |-> (ratio_code == (width_sel ? 2'd2 : 2'd1)));

   // R8
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_err |-> !res_valid);

   // R9
   sos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sos && !(up_valid && dn_ready))
         |=> (ratio_code == 2'd0 && !width_sel && !short_err && !res_valid));

   // R10
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sos |=> (res_valid || $stable(ratio_code)));
endmodule

bind hdr_inspector hdr_inspector_chk #(.IDX_W(IDX_W), .CMP_IDX(CMP_IDX)) chk_i (
   .clk(clk), .rst_n(rst_n), .sos(sos), .up_valid(up_valid),
   .dn_ready(dn_ready), .idx_q(idx_q), .cur_idx(cur_idx),
   .res_valid(res_valid), .ratio_code(ratio_code), .width_sel(width_sel),
   .is_encrypted(is_encrypted), .is_compressed(is_compressed),
   .short_err(short_err)
);

// File: tb/hdr_inspector_tb.sv
module hdr_inspector_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sos = 1'b0;
   logic        cfg_w32 = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [31:0] up_data = '0;
   logic        up_last = 1'b0;
   logic        dn_valid;
   logic        dn_ready = 1'b1;
   logic [31:0] dn_data;
   logic        res_valid;
   logic [1:0]  ratio_code;
   logic        width_sel;
   logic        is_encrypted;
   logic        is_compressed;
   logic        short_err;

   int tests = 0;
   int fails = 0;
   int res_cnt = 0;
   int pt_bad = 0;
   logic [1:0] got_ratio;
   logic got_w, got_enc, got_cmp;

   hdr_inspector dut_i (
      .clk(clk), .rst_n(rst_n), .sos(sos), .cfg_w32(cfg_w32),
      .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
      .up_last(up_last), .dn_valid(dn_valid), .dn_ready(dn_ready),
      .dn_data(dn_data), .res_valid(res_valid), .ratio_code(ratio_code),
      .width_sel(width_sel), .is_encrypted(is_encrypted),
      .is_compressed(is_compressed), .short_err(short_err)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         res_cnt++;
         got_ratio = ratio_code;
         got_w     = width_sel;
         got_enc   = is_encrypted;
         got_cmp   = is_compressed;
      end
   end

   function automatic int exp_ratio(input bit enc, input bit cmp, input bit w32);
      int r;
      if (cmp) r = 2;
      else if (enc) r = 1;
      else r = 0;
      if (w32 && r != 0) r = r + 1;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_stream();
      @(negedge clk);
      sos = 1'b1; up_valid = 1'b0; up_last = 1'b0; dn_ready = 1'b1;
      @(negedge clk);
      sos = 1'b0;
      #1;
      // R9: start of stream clears results
      chk(ratio_code == 2'd0 && !width_sel && !short_err && !is_encrypted &&
          !is_compressed, "R9 cleared by sos",
          {ratio_code, width_sel, short_err, is_encrypted, is_compressed}, 0);
      res_cnt = 0;
      pt_bad = 0;
   endtask

   task automatic run_stream(input int len, input logic [1:0] encf, input bit cmpb,
                             input bit w32, input int stall_pct);
      logic [31:0] d;
      bit acc;
      int exp_r;
      bit exp_enc;
      start_stream();
      cfg_w32 = w32;
      for (int i = 0; i < len; i++) begin
         d = $urandom;
         if (i == 69)  d[3:2] = encf;
         if (i == 229) d[1] = cmpb;
         up_valid = 1'b1; up_data = d; up_last = (i == len - 1);
         do begin
            dn_ready = (($urandom % 100) >= stall_pct);
            acc = dn_ready;
            #1;
            if (dn_valid !== up_valid || dn_data !== up_data || up_ready !== dn_ready)
               pt_bad++;
            @(negedge clk);
         end while (!acc);
      end
      up_valid = 1'b0; up_last = 1'b0; dn_ready = 1'b1;
      repeat (3) @(negedge clk);
      // R1: passthrough
      chk(pt_bad == 0, "R1 passthrough", pt_bad, 0);
      exp_enc = (encf != 2'd0);
      exp_r = exp_ratio(exp_enc, !cmpb, w32);
      if (len >= 230) begin
         // R5 (and R2: stalls do not advance the count)
         chk(res_cnt == 1, "R5 one result pulse", res_cnt, 1);
         chk(got_enc == exp_enc, "R3 encryption flag", got_enc, exp_enc);
         chk(got_cmp == !cmpb, "R4 compression flag", got_cmp, !cmpb);
         chk(got_ratio == exp_r, "R6/R7 ratio code", got_ratio, exp_r);
         chk(got_w == w32, "R7 width select", got_w, w32);
         chk(short_err == 1'b0, "R8 no error on full header", short_err, 0);
         // R10: results hold after the header
         chk(ratio_code == exp_r && width_sel == w32, "R10 result held",
             ratio_code, exp_r);
      end else begin
         // R8: short stream
         chk(short_err == 1'b1, "R8 short stream error", short_err, 1);
         chk(res_cnt == 0, "R8 no result on short stream", res_cnt, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state
      chk(ratio_code == 2'd0 && !res_valid && !short_err && !is_encrypted &&
          !width_sel, "R9 reset state",
          {ratio_code, res_valid, short_err, is_encrypted, width_sel}, 0);
      // Directed corners
      run_stream(230, 2'd0, 1'b1, 1'b0, 0);   // plain, x1
      run_stream(230, 2'd0, 1'b1, 1'b1, 0);   // plain wide stays x1
      run_stream(230, 2'd1, 1'b1, 1'b0, 0);   // encrypted x2
      run_stream(230, 2'd2, 1'b1, 1'b1, 20);  // encrypted wide x4
      run_stream(230, 2'd3, 1'b1, 1'b0, 0);
      run_stream(230, 2'd0, 1'b0, 1'b0, 0);   // compressed x4
      run_stream(231, 2'd0, 1'b0, 1'b1, 30);  // compressed wide x8
      run_stream(240, 2'd3, 1'b0, 1'b1, 0);   // both wide x8
      run_stream(229, 2'd1, 1'b0, 1'b1, 0);   // one word short
      run_stream(1,   2'd0, 1'b1, 1'b0, 0);
      run_stream(70,  2'd2, 1'b1, 1'b0, 10);
      run_stream(300, 2'd1, 1'b1, 1'b1, 40);  // R2 count saturates, R10 holds
      // Random streams
      for (int k = 0; k < 10; k++) begin
         int len;
         len = (($urandom % 5) == 0) ? int'($urandom % 229) + 1
                                     : 230 + int'($urandom % 60);
         run_stream(len, 2'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom % 50));
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule